// File: doc/BRIEF.md
# Framed Serial Shift Register

This block turns a byte into an asynchronous serial character and, with the same register, turns a serial character back into a byte. A single chain of flops holds the start bit, the data byte, an optional parity bit and the stop bit. A per-flop two-way multiplexer either loads the whole chain at once or shifts it one place toward the line end. A programmable bit-period timer produces the shift ticks. A small controller counts ticks, ends the frame with a one-cycle completion pulse and reports busy while a frame is in flight.

To transmit, the user presents a byte and pulses `load_req`. The framing bits are loaded alongside the data, and zeros enter the far end of the chain as it empties. To receive, the user pulses `cap_req` at the leading edge of an incoming start bit. The line level then enters the far end of the chain once per bit period, and the byte is read from fixed flop positions when the last bit arrives. The start and stop bits are checked, and so is parity when it is enabled. Receive timing is aligned by the caller; there is no oversampling.

Top module: `frame_shifter`

## Requirements
- R1: After a load is accepted, `tx_line` shows, from the next cycle, a 0 start bit, then `tx_data` least significant bit first, then the parity bit if enabled, then a 1 stop bit. Each bit lasts `bit_div`+1 clock cycles.
- R2: `tx_line` is 1 whenever no transmit is in progress, including throughout a receive.
- R3: `par_sel` encodes 2'b00 no parity, 2'b01 even, 2'b10 odd, and 2'b11 no parity. The parity bit makes the count of ones over data plus parity even (01) or odd (10). `par_sel` is sampled only when a frame is accepted, so later changes have no effect on that frame.
- R4: `done` is a single-cycle pulse in the cycle after the final tick: 10 ticks without parity, 11 with. `busy` is low in that same cycle and falls only together with `done`.
- R5: In receive, `rx_line` is sampled at the end of each bit period. `rx_data` takes the 8 bits following the start bit, LSB first, in the `done` cycle of a receive, and otherwise holds its value.
- R6: `frame_err` is set at the end of a receive if the sampled start bit was 1 or the sampled stop bit was 0, and is cleared otherwise.
- R7: `par_err` is set at the end of a receive with parity enabled if the sampled parity bit does not match the selected parity of the sampled data. Without parity it is 0.
- R8: `busy` is high from the cycle after acceptance until the frame ends. `load_req` and `cap_req` are ignored while busy: the frame in progress continues unchanged.
- R9: When `load_req` and `cap_req` are both high while idle, the transmit is taken.
- R10: `bit_div` = 0 gives one bit per clock cycle. The default 20-bit divider reaches 454544, which gives 110 bit/s from a 50 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_div | input | DIV_W | Bit period minus one, in clock cycles |
| par_sel | input | 2 | Parity selection (R3 encoding) |
| load_req | input | 1 | Request to transmit `tx_data` |
| tx_data | input | DATA_W | Byte to transmit |
| cap_req | input | 1 | Request to capture a frame from `rx_line` |
| rx_line | input | 1 | Serial receive input |
| tx_line | output | 1 | Serial transmit output, idles at 1 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_data | output | DATA_W | Last received byte |
| frame_err | output | 1 | Last receive had a bad start or stop bit |
| par_err | output | 1 | Last receive had a parity mismatch |

## Verification
On every cycle, the assertions check four things: the idle line level, that the start bit appears right after a transmit is accepted, that the completion pulse lasts a single cycle and coincides with the fall of busy, and that the receive results change only on completion. The bit order, the parity values, the tick count for each parity setting, the refusal of requests during a frame and the error flags depend on the data. Only the bench's reference model can show these, as it runs frames through with different divisors, parity modes and corrupted start, stop and parity bits.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_TX   = 2'b01,
    ST_RX   = 2'b10
  } fss_state_e;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  function automatic logic par_enabled(input logic [1:0] sel);
    return (sel == PAR_EVEN) || (sel == PAR_ODD);
  endfunction
endpackage

// File: rtl/fss_bit_timer.sv
module fss_bit_timer #(
  parameter int unsigned DIV_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick = run && (cnt_q == div);
    if (restart || !run || tick) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fss_shift_chain.sv
module fss_shift_chain #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic         ser_in,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic from_left;
    if (i == W - 1) begin : g_end
      assign from_left = ser_in;
    end else begin : g_mid
      assign from_left = q[i+1];
    end
    always_comb begin
      if (load)       d[i] = load_val[i];
      else if (shift) d[i] = from_left;
      else            d[i] = q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= d;
  end
endmodule

// File: rtl/fss_frame_ctrl.sv
module fss_frame_ctrl
  import fss_pkg::*;
#(
  parameter int unsigned CHAIN_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_req,
  input  logic       cap_req,
  input  logic       tick,
  input  logic       with_par,
  output fss_state_e state,
  output logic       accept_tx,
  output logic       accept_rx,
  output logic       last,
  output logic       done
);
  localparam int unsigned CNT_W = $clog2(CHAIN_W + 1);
  localparam logic [CNT_W-1:0] N_PAR   = CNT_W'(CHAIN_W);
  localparam logic [CNT_W-1:0] N_NOPAR = CNT_W'(CHAIN_W - 1);

  fss_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d;
  logic [CNT_W-1:0] nbits;

  always_comb begin
    nbits     = with_par ? N_PAR : N_NOPAR;
    accept_tx = (state_q == ST_IDLE) && load_req;
    accept_rx = (state_q == ST_IDLE) && cap_req && !load_req;
    last      = (state_q != ST_IDLE) && tick && (cnt_q == nbits - 1'b1);
    state_d   = state_q;
    cnt_d     = cnt_q;
    done_d    = 1'b0;
    if (accept_tx) begin
      state_d = ST_TX;
      cnt_d   = '0;
    end else if (accept_rx) begin
      state_d = ST_RX;
      cnt_d   = '0;
    end else if (last) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      done_d  = 1'b1;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done    <= done_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import fss_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic [1:0]        par_sel,
  input  logic              load_req,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              cap_req,
  input  logic              rx_line,
  output logic              tx_line,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              frame_err,
  output logic              par_err
);
  localparam int unsigned CHAIN_W = DATA_W + 3;

  fss_state_e        state;
  logic              accept_tx, accept_rx, last, tick;
  logic [1:0]        par_q;
  logic              par_on_q;
  logic [CHAIN_W-1:0] chain_q, load_val;
  logic              ser_in, par_bit;
  logic [DATA_W-1:0] rx_data_d;
  logic              start_s, par_s, odd_q;
  logic              ferr_d, perr_d, capture_end;

  // frame settings held for the whole frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       par_q <= 2'b00;
    else if (accept_tx || accept_rx)  par_q <= par_sel;
  end

  assign par_on_q = par_enabled(par_q);
  assign odd_q    = (par_q == PAR_ODD);

  fss_frame_ctrl #(.CHAIN_W(CHAIN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (load_req),
    .cap_req   (cap_req),
    .tick      (tick),
    .with_par  (par_on_q),
    .state     (state),
    .accept_tx (accept_tx),
    .accept_rx (accept_rx),
    .last      (last),
    .done      (done)
  );

  fss_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state != ST_IDLE),
    .restart (accept_tx || accept_rx),
    .div     (bit_div),
    .tick    (tick)
  );

  // transmit image: stop, parity-or-stop, data, start
  always_comb begin
    par_bit  = (^tx_data) ^ (par_sel == PAR_ODD);
    load_val = {1'b1, (par_enabled(par_sel) ? par_bit : 1'b1), tx_data, 1'b0};
    ser_in   = (state == ST_RX) ? rx_line : 1'b0;
  end

  fss_shift_chain #(.W(CHAIN_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_tx),
    .shift    (tick),
    .ser_in   (ser_in),
    .load_val (load_val),
    .q        (chain_q)
  );

  // receive result, taken from the chain as the last bit enters
  always_comb begin
    if (par_on_q) begin
      rx_data_d = chain_q[DATA_W+1:2];
      start_s   = chain_q[1];
      par_s     = chain_q[DATA_W+2];
    end else begin
      rx_data_d = chain_q[DATA_W+2:3];
      start_s   = chain_q[2];
      par_s     = 1'b0;
    end
    ferr_d      = start_s || !rx_line;
    perr_d      = par_on_q && (par_s != ((^rx_data_d) ^ odd_q));
    capture_end = last && (state == ST_RX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
    end else if (capture_end) begin
      rx_data   <= rx_data_d;
      frame_err <= ferr_d;
      par_err   <= perr_d;
    end
  end

  assign tx_line = (state == ST_TX) ? chain_q[0] : 1'b1;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_req,
  input logic              cap_req,
  input logic              tx_line,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] rx_data,
  input logic              frame_err,
  input logic              par_err
);
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line); // R2

  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load_req) |=> (busy && !tx_line)); // R1

  AST_RX_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cap_req && !load_req) |=> (busy && tx_line)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4

  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R4

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({rx_data, frame_err, par_err})); // R5
endmodule

bind frame_shifter fss_checker #(.DATA_W(DATA_W)) u_fss_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_req  (load_req),
  .cap_req   (cap_req),
  .tx_line   (tx_line),
  .busy      (busy),
  .done      (done),
  .rx_data   (rx_data),
  .frame_err (frame_err),
  .par_err   (par_err)
);

// File: tb/tb_frame_shifter.sv
`timescale 1ns/1ps
module tb_frame_shifter;
  localparam int DW = 8;
  localparam int VW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [VW-1:0] bit_div;
  logic [1:0]    par_sel;
  logic          load_req, cap_req, rx_line;
  logic [DW-1:0] tx_data;
  logic          tx_line, busy, done, frame_err, par_err;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  frame_shifter #(.DATA_W(DW), .DIV_W(VW)) dut (
    .clk(clk), .rst_n(rst_n), .bit_div(bit_div), .par_sel(par_sel),
    .load_req(load_req), .tx_data(tx_data), .cap_req(cap_req),
    .rx_line(rx_line), .tx_line(tx_line), .busy(busy), .done(done),
    .rx_data(rx_data), .frame_err(frame_err), .par_err(par_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int       m_state;   // 0 idle, 1 send, 2 capture
  int       m_cnt, m_bit, m_n;
  bit       m_frame [0:10];
  bit       m_samp  [0:10];
  bit [1:0] m_par;
  bit [7:0] m_rxd;
  bit       m_fe, m_pe, m_done;

  function automatic bit p_on(input bit [1:0] s);
    return (s == 2'b01) || (s == 2'b10);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_bit = 0; m_n = 10; m_par = 0;
      m_rxd = 0; m_fe = 0; m_pe = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_state == 0) begin
        if (load_req || cap_req) begin
          m_par = par_sel;
          m_n   = p_on(par_sel) ? 11 : 10;
          m_cnt = 0; m_bit = 0;
          if (load_req) begin
            m_state = 1;
            m_frame[0] = 0;
            for (int i = 0; i < 8; i++) m_frame[1+i] = tx_data[i];
            m_frame[9]  = p_on(par_sel) ? ((^tx_data) ^ (par_sel == 2'b10)) : 1'b1;
            m_frame[10] = 1;
          end else begin
            m_state = 2;
          end
        end
      end else if (m_cnt == int'(bit_div)) begin
        m_cnt = 0;
        if (m_state == 2) m_samp[m_bit] = rx_line;
        m_bit++;
        if (m_bit == m_n) begin
          if (m_state == 2) begin
            for (int i = 0; i < 8; i++) m_rxd[i] = m_samp[1+i];
            m_fe = m_samp[0] || !m_samp[m_n-1];
            m_pe = p_on(m_par) && (m_samp[9] != ((^m_rxd) ^ (m_par == 2'b10)));
          end
          m_state = 0;
          m_done  = 1;
        end
      end else begin
        m_cnt++;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 tx_line", tx_line, (m_state == 1) ? m_frame[m_bit] : 1'b1);
      chk("R8 busy", busy, m_state != 0);
      chk("R4 done", done, m_done);
      chk("R5 rx_data", rx_data, m_rxd);
      chk("R6 frame_err", frame_err, m_fe);
      chk("R7 par_err", par_err, m_pe);
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] ps, input int dv);
    bit_div = VW'(dv); par_sel = ps; tx_data = d; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    par_sel  = ~ps;  // R3: later changes must not affect the frame
    chk("R1 start bit", tx_line, 1'b0);
    wait_idle();
  endtask

  task automatic recv(input logic [7:0] d, input logic [1:0] ps, input int dv,
                      input bit bad_start, input bit bad_stop, input bit bad_par);
    bit bits [0:10];
    int n;
    n = p_on(ps) ? 11 : 10;
    bits[0] = bad_start;
    for (int i = 0; i < 8; i++) bits[1+i] = d[i];
    if (p_on(ps)) begin
      bits[9]  = ((^d) ^ (ps == 2'b10)) ^ bad_par;
      bits[10] = !bad_stop;
    end else begin
      bits[9] = !bad_stop;
    end
    bit_div = VW'(dv); par_sel = ps; cap_req = 1'b1; rx_line = bits[0];
    @(negedge clk);
    cap_req = 1'b0;
    for (int k = 0; k < n; k++) begin
      rx_line = bits[k];
      repeat (dv + 1) @(negedge clk);
    end
    rx_line = 1'b1;
    wait_idle();
    chk("R5 received byte", rx_data, d);
    chk("R6 framing flag", frame_err, bad_start | bad_stop);
    chk("R7 parity flag", par_err, bad_par & p_on(ps));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_div = VW'(3); par_sel = 2'b00; load_req = 1'b0;
    cap_req = 1'b0; rx_line = 1'b1; tx_data = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset line", tx_line, 1'b1);
    chk("R8 reset busy", busy, 1'b0);
    chk("R4 reset done", done, 1'b0);
    chk("R5 reset rx_data", rx_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    send(8'hA5, 2'b00, 3);   // R1 no parity
    send(8'h3C, 2'b01, 2);   // R3 even
    send(8'h01, 2'b10, 0);   // R3 odd, R10 one bit per clock
    send(8'h80, 2'b11, 1);   // R3 code 11 is no parity
    send(8'hFF, 2'b01, 4);

    // R8: requests during a transmit are ignored
    bit_div = VW'(2); par_sel = 2'b10; tx_data = 8'h5A; load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    repeat (7) @(negedge clk);
    tx_data = 8'hFF; load_req = 1'b1; cap_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0; cap_req = 1'b0;
    chk("R8 busy kept", busy, 1'b1);
    wait_idle();

    // R9: both requests at idle give a transmit
    tx_data = 8'h0F; par_sel = 2'b00; bit_div = VW'(1);
    load_req = 1'b1; cap_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0; cap_req = 1'b0;
    chk("R9 transmit chosen", tx_line, 1'b0);
    wait_idle();

    recv(8'hC3, 2'b00, 2, 0, 0, 0);  // R5
    recv(8'h96, 2'b01, 1, 0, 0, 0);  // R5 even
    recv(8'h7E, 2'b10, 3, 0, 0, 0);  // R5 odd
    recv(8'h11, 2'b00, 1, 0, 1, 0);  // R6 bad stop
    recv(8'h22, 2'b01, 2, 1, 0, 0);  // R6 bad start
    recv(8'h34, 2'b10, 1, 0, 0, 1);  // R7 parity mismatch
    recv(8'h34, 2'b11, 0, 0, 0, 1);  // R7 no parity, no flag; R10
    send(8'h6D, 2'b10, 2);           // R5 rx results held over a transmit
    chk("R5 hold after send", rx_data, 8'h34);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule